// File: doc/BRIEF.md
# Transceiver Reset and Power Control Register File

This block is the control register file of a line transceiver. It holds seven 4-bit registers and three 8-bit registers and an interrupt flag. Register 0 is the control nibble. Its four bits request a software reset, a transmit power-down, a deep power-down and a "return to normal" clear of selected test bits. A plain parallel read/write bus stands in for the serial control port. It stays usable under every software-driven reset or power state.

From the control nibble the block drives four things: a reset for the internal datapath, a force-idle control for the transmitter, a gate on the serial data output and a clock-enable for the gated clock domain. It also watches a 2-bit received-line-state input during transmit power-down. Any change of that input raises a sticky interrupt. The initial value of nibble register 3 depends on a terminal/network mode input, which is sampled while a reset is active.

Top module: `xcvr_pwr_ctl`

## Requirements
- R1: After a hardware reset, all nibble registers read 0 except address 3. Address 3 reads 0x8 if `mode_te` was 1 during the reset and 0x0 if it was 0. The byte registers and the interrupt flag read 0. `core_rst_n` and `core_clk_en` are 1 and `tx_force_info0` is 0.
- R2: The address map is as follows. Address 0 is the control nibble: bit 3 software reset, bit 2 transmit power-down, bit 1 deep power-down, bit 0 return-to-normal. Addresses 1 to 6 are nibbles that store the low 4 bits of `cpu_wdata`. Address 8 is an auxiliary byte. Address 9 is a test byte, with bit 0 the test tone and bit 1 the loopback. Address 10 is a config byte, with bit 1 keeping data on the output during power-down. Address 11 bit 0 is the interrupt flag. Other addresses read 0 and ignore writes. A write takes effect at the clock edge, and `cpu_rdata` follows `cpu_addr` without a clock.
- R3: While control bit 3 is 1, `core_rst_n` is 0 from the cycle after the write. From the following cycle, every register except the control nibble holds its initial value and ignores writes. The control nibble stays writable, and writing bit 3 back to 0 releases the reset.
- R4: The address 3 initial value follows `mode_te` as sampled during the last reset, hardware or software. Changing `mode_te` outside a reset does not alter the register.
- R5: While control bit 2 is 1, `tx_force_info0` is 1. In that state `tx_data_out` is 1, unless config bit 1 is set, in which case it follows `tx_data_in`.
- R6: While control bit 2 is 1, any change of `rx_state` sets the interrupt flag at the next clock edge. The flag drives `rx_chg_irq` and stays set until 1 is written to address 11 bit 0. No change sets it while control bit 2 is 0.
- R7: While control bit 1 is 1, `core_clk_en` is 0, `core_rst_n` is 0, `tx_force_info0` is 1 and `tx_data_out` is 1. The registers other than the control nibble are held as in R3.
- R8: While control bit 0 is 1, the auxiliary byte and bits 0 and 1 of the test byte are cleared from the cycle after the write. Writes to those bits have no effect. The other test byte bits stay writable.
- R9: Driving `rst_n` low drops `core_rst_n` at once, without a clock edge. After `rst_n` rises, `core_rst_n` returns to 1 at the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control port clock, never gated |
| rst_n | input | 1 | Hardware reset, active low |
| mode_te | input | 1 | 1 = terminal mode, 0 = network mode |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| rx_state | input | 2 | Received line state |
| tx_data_in | input | 1 | Serial data from the datapath |
| tx_data_out | output | 1 | Serial data output after gating |
| tx_force_info0 | output | 1 | Holds the transmitter in its idle line state |
| rx_chg_irq | output | 1 | Sticky receive-change interrupt |
| core_rst_n | output | 1 | Reset to the internal datapath, active low |
| core_clk_en | output | 1 | Enable for the gated clock domain |

## Verification
Control-bit effects on `core_rst_n`, `core_clk_en`, `tx_force_info0` and `tx_data_out` are due in the cycle that directly follows the write edge. Register clearing under software reset, deep power-down and return-to-normal is due one edge later. An interrupt is due one edge after `rx_state` changes. Hardware reset release takes two edges, and the mode-dependent load takes a third. The bench drives inputs on falling edges and samples outputs one time unit later. For each delayed effect it waits the exact number of falling edges counted above before comparing, so a result that lands one cycle early or late is reported.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  // control nibble bit positions
  localparam int CTL_SWRST = 3;
  localparam int CTL_TXPD  = 2;
  localparam int CTL_DEEP  = 1;
  localparam int CTL_RTN   = 0;
  // byte register addresses
  localparam int ADR_AUX = 8;
  localparam int ADR_TST = 9;
  localparam int ADR_CFG = 10;
  localparam int ADR_IRQ = 11;
  // field positions inside the byte registers
  localparam int TST_TONE_BIT = 0;
  localparam int TST_LOOP_BIT = 1;
  localparam int CFG_KEEP_BIT = 1;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_rx_watch.sv
module pwr_rx_watch #(
  parameter int RX_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RX_W-1:0] rx_state,
  input  logic            watch,
  input  logic            hold,
  input  logic            clr,
  output logic            flag
);
  logic [RX_W-1:0] prev_q;
  logic            flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (hold)                              flag_d = 1'b0;
    else if (watch && (rx_state != prev_q)) flag_d = 1'b1;
    else if (clr)                          flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= rx_state;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_ctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NIB_W    = 4,
  parameter int NUM_NIB  = 7,
  parameter int BYTE_W   = 8,
  parameter int MODE_IDX = 3,
  parameter logic [NIB_W-1:0] TE_INIT = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_te,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              irq_flag,
  output logic [BYTE_W-1:0] rdata,
  output logic [NIB_W-1:0]  ctl_q,
  output logic [BYTE_W-1:0] aux_q,
  output logic [BYTE_W-1:0] tst_q,
  output logic [BYTE_W-1:0] cfg_q,
  output logic              init_hold
);
  localparam logic [BYTE_W-1:0] RTN_TST_MASK =
    BYTE_W'((1 << TST_TONE_BIT) | (1 << TST_LOOP_BIT));

  logic             init_pend_q;
  logic [NIB_W-1:0] ctl_d;
  logic [BYTE_W-1:0] aux_d, tst_d, cfg_d;
  logic [NIB_W-1:0] nib_rd [1:NUM_NIB-1];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign init_hold = init_pend_q | ctl_q[CTL_SWRST] | ctl_q[CTL_DEEP];

  // control nibble: only a hardware reset clears it
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && hit(addr, 0)) ctl_d = wdata[NIB_W-1:0];
  end

  // byte registers
  always_comb begin
    aux_d = aux_q;
    tst_d = tst_q;
    cfg_d = cfg_q;
    if (init_hold) begin
      aux_d = '0;
      tst_d = '0;
      cfg_d = '0;
    end else begin
      if (wr_en && hit(addr, ADR_AUX)) aux_d = wdata;
      if (wr_en && hit(addr, ADR_TST)) tst_d = wdata;
      if (wr_en && hit(addr, ADR_CFG)) cfg_d = wdata;
      if (ctl_q[CTL_RTN]) begin
        aux_d = '0;
        tst_d = tst_d & ~RTN_TST_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_pend_q <= 1'b1;
      ctl_q       <= '0;
      aux_q       <= '0;
      tst_q       <= '0;
      cfg_q       <= '0;
    end else begin
      init_pend_q <= 1'b0;
      ctl_q       <= ctl_d;
      aux_q       <= aux_d;
      tst_q       <= tst_d;
      cfg_q       <= cfg_d;
    end
  end

  // general nibble registers 1..NUM_NIB-1
  for (genvar gi = 1; gi < NUM_NIB; gi++) begin : g_nib
    logic [NIB_W-1:0] q, d, init_v;
    assign init_v = (gi == MODE_IDX && mode_te) ? TE_INIT : '0;
    always_comb begin
      d = q;
      if (init_hold)                d = init_v;
      else if (wr_en && hit(addr, gi)) d = wdata[NIB_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign nib_rd[gi] = q;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (hit(addr, 0)) rdata = BYTE_W'(ctl_q);
    for (int i = 1; i < NUM_NIB; i++)
      if (hit(addr, i)) rdata = BYTE_W'(nib_rd[i]);
    if (hit(addr, ADR_AUX)) rdata = aux_q;
    if (hit(addr, ADR_TST)) rdata = tst_q;
    if (hit(addr, ADR_CFG)) rdata = cfg_q;
    if (hit(addr, ADR_IRQ)) rdata = BYTE_W'(irq_flag);
  end
endmodule

// File: rtl/xcvr_pwr_ctl.sv
module xcvr_pwr_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NIB_W       = 4,
  parameter int NUM_NIB     = 7,
  parameter int BYTE_W      = 8,
  parameter int RX_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_te,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic [RX_W-1:0]   rx_state,
  input  logic              tx_data_in,
  output logic              tx_data_out,
  output logic              tx_force_info0,
  output logic              rx_chg_irq,
  output logic              core_rst_n,
  output logic              core_clk_en
);
  logic              rst_n_sync;
  logic [NIB_W-1:0]  ctl_q;
  logic [BYTE_W-1:0] aux_q, tst_q, cfg_q;
  logic              init_hold;
  logic              irq_clr;
  logic              irq_flag;
  logic              tx_gate;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  pwr_regfile #(
    .ADDR_W (ADDR_W),
    .NIB_W  (NIB_W),
    .NUM_NIB(NUM_NIB),
    .BYTE_W (BYTE_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .mode_te  (mode_te),
    .wr_en    (cpu_wr),
    .addr     (cpu_addr),
    .wdata    (cpu_wdata),
    .irq_flag (irq_flag),
    .rdata    (cpu_rdata),
    .ctl_q    (ctl_q),
    .aux_q    (aux_q),
    .tst_q    (tst_q),
    .cfg_q    (cfg_q),
    .init_hold(init_hold)
  );

  assign irq_clr = cpu_wr && (cpu_addr == ADDR_W'(ADR_IRQ)) && cpu_wdata[0];

  pwr_rx_watch #(.RX_W(RX_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .rx_state(rx_state),
    .watch   (ctl_q[CTL_TXPD]),
    .hold    (init_hold),
    .clr     (irq_clr),
    .flag    (irq_flag)
  );

  assign tx_gate        = ctl_q[CTL_DEEP] | (ctl_q[CTL_TXPD] & ~cfg_q[CFG_KEEP_BIT]);
  assign tx_data_out    = tx_gate | tx_data_in;
  assign tx_force_info0 = ctl_q[CTL_TXPD] | ctl_q[CTL_DEEP];
  assign core_rst_n     = rst_n_sync & ~ctl_q[CTL_SWRST] & ~ctl_q[CTL_DEEP];
  assign core_clk_en    = ~ctl_q[CTL_DEEP];
  assign rx_chg_irq     = irq_flag;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk #(
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NIB_W-1:0]  ctl_q,
  input logic [BYTE_W-1:0] aux_q,
  input logic [BYTE_W-1:0] tst_q,
  input logic [BYTE_W-1:0] cfg_q,
  input logic              irq,
  input logic              irq_clr,
  input logic              init_hold,
  input logic              core_rst_n,
  input logic              core_clk_en,
  input logic              tx_force_info0,
  input logic              tx_data_out
);
  assert_swrst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_n && $past(!core_rst_n)) |-> (aux_q == '0 && tst_q == '0 && cfg_q == '0));

  assert_txpd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2] && !cfg_q[1]) |-> (tx_data_out && tx_force_info0));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !init_hold) |=> irq);

  assert_irq_only_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ctl_q[2]) |=> !irq);

  assert_deep_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |-> (!core_clk_en && !core_rst_n && tx_force_info0 && tx_data_out));

  assert_rtn_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && $past(ctl_q[0])) |-> (aux_q == '0 && tst_q[1:0] == 2'b00));
endmodule

bind xcvr_pwr_ctl pwr_ctl_chk #(.NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_q         (ctl_q),
  .aux_q         (aux_q),
  .tst_q         (tst_q),
  .cfg_q         (cfg_q),
  .irq           (irq_flag),
  .irq_clr       (irq_clr),
  .init_hold     (init_hold),
  .core_rst_n    (core_rst_n),
  .core_clk_en   (core_clk_en),
  .tx_force_info0(tx_force_info0),
  .tx_data_out   (tx_data_out)
);

// File: tb/tb_xcvr_pwr_ctl.sv
module tb_xcvr_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr, write data, expected read-back}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd1,  8'h05, 8'h05},
    {4'd6,  8'hFF, 8'h0F},
    {4'd8,  8'hA5, 8'hA5},
    {4'd9,  8'h0C, 8'h0C},
    {4'd10, 8'h01, 8'h01},
    {4'd3,  8'h07, 8'h07},
    {4'd7,  8'h33, 8'h00},
    {4'd12, 8'h5A, 8'h00}
  };

  logic clk, rst_n, mode_te, cpu_wr, tx_data_in;
  logic [3:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [1:0] rx_state;
  logic tx_data_out, tx_force_info0, rx_chg_irq, core_rst_n, core_clk_en;
  int n_chk, n_bad;

  xcvr_pwr_ctl dut (
    .clk(clk), .rst_n(rst_n), .mode_te(mode_te), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_state(rx_state), .tx_data_in(tx_data_in), .tx_data_out(tx_data_out),
    .tx_force_info0(tx_force_info0), .rx_chg_irq(rx_chg_irq),
    .core_rst_n(core_rst_n), .core_clk_en(core_clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    cpu_addr = a;
    #1;
    chk(req, cpu_rdata, exp);
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; mode_te = 1'b1; cpu_wr = 1'b0; cpu_addr = '0;
    cpu_wdata = '0; rx_state = 2'b00; tx_data_in = 1'b0;
    nclk(3);
    rst_n = 1'b1;
    nclk(5);
    // R1: reset state, terminal mode
    for (int a = 0; a < 7; a++)
      rd_chk("R1 nibble", 4'(a), (a == 3) ? 8'h08 : 8'h00);
    rd_chk("R1 aux", 4'd8, 8'h00);
    rd_chk("R1 irq", 4'd11, 8'h00);
    chk("R1 core_rst_n", {7'd0, core_rst_n}, 8'h01);
    chk("R1 clk_en", {7'd0, core_clk_en}, 8'h01);
    chk("R1 force", {7'd0, tx_force_info0}, 8'h00);

    // R2: vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(VEC[v][19:16], VEC[v][15:8]);
      rd_chk("R2 vector", VEC[v][19:16], VEC[v][7:0]);
    end

    // R3: software reset
    wr(4'd1, 8'h05); wr(4'd8, 8'hFF);
    wr(4'd0, 8'h08);
    chk("R3 core_rst_n low", {7'd0, core_rst_n}, 8'h00);
    nclk(1);
    rd_chk("R3 nib1 cleared", 4'd1, 8'h00);
    rd_chk("R3 aux cleared", 4'd8, 8'h00);
    rd_chk("R3 nib3 init", 4'd3, 8'h08);
    wr(4'd1, 8'h03);
    rd_chk("R3 write ignored", 4'd1, 8'h00);
    rd_chk("R3 ctl kept", 4'd0, 8'h08);
    wr(4'd0, 8'h00);
    chk("R3 release", {7'd0, core_rst_n}, 8'h01);
    wr(4'd1, 8'h03);
    rd_chk("R3 writable again", 4'd1, 8'h03);

    // R4: mode sampled only during reset
    mode_te = 1'b0;
    nclk(2);
    rd_chk("R4 nib3 unchanged", 4'd3, 8'h08);
    wr(4'd0, 8'h08); wr(4'd0, 8'h00);
    rd_chk("R4 nib3 network", 4'd3, 8'h00);
    mode_te = 1'b1;

    // R5: transmit power-down
    tx_data_in = 1'b0;
    wr(4'd0, 8'h04);
    chk("R5 force", {7'd0, tx_force_info0}, 8'h01);
    chk("R5 data ones", {7'd0, tx_data_out}, 8'h01);
    wr(4'd10, 8'h02);
    chk("R5 keep data", {7'd0, tx_data_out}, 8'h00);

    // R6: receive change interrupt
    @(negedge clk); rx_state = 2'b10;
    nclk(1);
    chk("R6 irq set", {7'd0, rx_chg_irq}, 8'h01);
    nclk(2);
    chk("R6 irq sticky", {7'd0, rx_chg_irq}, 8'h01);
    wr(4'd11, 8'h01);
    chk("R6 irq cleared", {7'd0, rx_chg_irq}, 8'h00);
    wr(4'd0, 8'h00);
    @(negedge clk); rx_state = 2'b01;
    nclk(2);
    chk("R6 no irq outside pd", {7'd0, rx_chg_irq}, 8'h00);

    // R7: deep power-down
    wr(4'd1, 8'h06);
    wr(4'd0, 8'h02);
    chk("R7 clk_en", {7'd0, core_clk_en}, 8'h00);
    chk("R7 core_rst_n", {7'd0, core_rst_n}, 8'h00);
    chk("R7 force", {7'd0, tx_force_info0}, 8'h01);
    chk("R7 data ones", {7'd0, tx_data_out}, 8'h01);
    nclk(1);
    rd_chk("R7 nib1 held", 4'd1, 8'h00);
    rd_chk("R7 ctl readable", 4'd0, 8'h02);
    wr(4'd0, 8'h00);

    // R8: return to normal
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
    wr(4'd0, 8'h01);
    nclk(1);
    rd_chk("R8 aux cleared", 4'd8, 8'h00);
    rd_chk("R8 test bits cleared", 4'd9, 8'hFC);
    wr(4'd9, 8'h13);
    rd_chk("R8 write masked", 4'd9, 8'h10);
    wr(4'd0, 8'h00);
    wr(4'd9, 8'h03);
    rd_chk("R8 released", 4'd9, 8'h03);

    // R9: asynchronous hardware reset, synchronous release; R1 network mode
    @(negedge clk); #2;
    rst_n = 1'b0; mode_te = 1'b0;
    #1;
    chk("R9 async assert", {7'd0, core_rst_n}, 8'h00);
    rd_chk("R9 regs cleared", 4'd9, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    nclk(1);
    chk("R9 still in reset", {7'd0, core_rst_n}, 8'h00);
    nclk(1);
    chk("R9 released", {7'd0, core_rst_n}, 8'h01);
    nclk(2);
    rd_chk("R1 nib3 network", 4'd3, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule